// File: doc/BRIEF.md
# Truncated Fixed-Point Powering Unit

This block raises a small unsigned fraction to the power two or three and returns only the top bits of the result. It is meant to follow the folding stage of a symmetric polynomial term evaluator. The operand is the folded offset inside a segment. One implicit half-ulp bit is placed below its least significant bit, so the error from input bits dropped earlier is centred.

The power is built from an explicit array of bit products. Only the products whose weight reaches a chosen cut weight are formed and summed. A constant of half the largest possible dropped mass is added to centre the error. The sum is then cut to the output width, and it saturates instead of wrapping. The circuit is purely combinational. The exponent, the operand width, the internal cut and the output width are parameters. The bias is derived from them when the design elaborates.

Top module: `trunc_power`

## Requirements
- R1: The operand `x_i` (W bits) stands for the fraction z = (2·x_i + 1)·2^-(W+1). With W = 4 and x_i = 5, z = 11/32.
- R2: `y_o` is an unsigned fraction of LAMBDA bits with LSB weight 2^-LAMBDA. Let s be the summed value of every dropped bit product when all operand bits are one. For every operand, 2·|y_o·2^-LAMBDA − z^K| < s + 2·2^-MU + 2·2^-LAMBDA. The result never wraps: an all-ones operand gives a set MSB.
- R3: A bit product z_p·z_q(·z_r) uses the bit at position p, which has weight 2^-p with position 1 the MSB of z. It is kept only when p+q(+r) ≤ MU. With MU = K·(W+1) nothing is dropped, and y_o equals floor(z^K·2^LAMBDA) exactly.
- R4: The bias round(s/2) is added before truncation, so the error is two-sided. With LAMBDA = MU, 2·|y_o·2^-MU − z^K| < s + 4·2^-MU for every operand.
- R5: The exponent K may be 2 (squaring) or 3 (cubing), and the bound of R2 holds for both.
- R6: When the operand MSB is clear, the output MSB is clear.
- R7: The output depends only on the present operand, with no stored state. A new operand is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | W | Folded segment offset; the implicit half-ulp is appended internally |
| y_o | output | LAMBDA | Truncated, bias-centred power of the operand |

## Verification
Every result of this block is due with zero cycles of latency, because no register sits between the operand and the output. The bench changes the operand just after a rising edge and reads the output at the next falling edge, half a period later. Each read therefore sees only the operand applied in that cycle. Back-to-back operands in adjacent cycles show that nothing from the earlier operand carries over.

// File: rtl/trunc_power_pkg.sv
package trunc_power_pkg;

    typedef enum logic [1:0] {
        PWR_SQUARE = 2'd2,
        PWR_CUBE   = 2'd3
    } power_kind_e;

    // Accumulator holds a value below one in MU fraction bits plus headroom.
    function automatic int acc_width(input int mu);
        return mu + 3;
    endfunction

    // Largest total value of the dropped bit products, in units of 2^-(k*n).
    function automatic longint dropped_mass(input int k, input int n, input int mu);
        longint s;
        int     m;
        s = 0;
        for (int p = 1; p <= n; p++) begin
            for (int q = p; q <= n; q++) begin
                if (k == 2) begin
                    m = (p == q) ? 1 : 2;
                    if (p + q > mu) s += longint'(m) <<< (k * n - p - q);
                end else begin
                    for (int r = q; r <= n; r++) begin
                        if (p == q && q == r)      m = 1;
                        else if (p == q || q == r) m = 3;
                        else                       m = 6;
                        if (p + q + r > mu) s += longint'(m) <<< (k * n - p - q - r);
                    end
                end
            end
        end
        return s;
    endfunction

    // Half the dropped mass, rounded to the internal cut weight 2^-mu.
    function automatic longint centre_bias(input int k, input int n, input int mu);
        int d;
        d = k * n - mu;
        if (d <= 0) return 0;
        return (dropped_mass(k, n, mu) + (longint'(1) <<< d)) >>> (d + 1);
    endfunction

endpackage

// File: rtl/square_array.sv
module square_array #(
    parameter int N     = 10,
    parameter int MU    = 14,
    parameter int ACC_W = 17
) (
    input  logic [N-1:0]     z_i,
    output logic [ACC_W-1:0] acc_o
);
    // Folded squaring array: diagonal bits reduce to z_p, off-diagonal pairs doubled.
    always_comb begin
        acc_o = '0;
        for (int p = 1; p <= N; p++) begin
            if (2 * p <= MU && z_i[N-p])
                acc_o += ACC_W'(1) << (MU - 2 * p);
            for (int q = p + 1; q <= N; q++) begin
                if (p + q <= MU && z_i[N-p] && z_i[N-q])
                    acc_o += ACC_W'(2) << (MU - p - q);
            end
        end
    end

    always_comb begin
        if (!$isunknown(z_i))
            assert_kept_below_one_R3: assert (acc_o[ACC_W-1:MU] == '0)
                else $error("kept square products reached one");
    end
endmodule

// File: rtl/cube_array.sv
module cube_array #(
    parameter int N     = 7,
    parameter int MU    = 14,
    parameter int ACC_W = 17
) (
    input  logic [N-1:0]     z_i,
    output logic [ACC_W-1:0] acc_o
);
    // Unordered triples, each weighted by its number of orderings.
    always_comb begin
        int m;
        acc_o = '0;
        for (int p = 1; p <= N; p++) begin
            for (int q = p; q <= N; q++) begin
                for (int r = q; r <= N; r++) begin
                    if (p == q && q == r)      m = 1;
                    else if (p == q || q == r) m = 3;
                    else                       m = 6;
                    if (p + q + r <= MU && z_i[N-p] && z_i[N-q] && z_i[N-r])
                        acc_o += ACC_W'(m) << (MU - p - q - r);
                end
            end
        end
    end

    always_comb begin
        if (!$isunknown(z_i))
            assert_cube_below_one_R5: assert (acc_o[ACC_W-1:MU] == '0)
                else $error("kept cube products reached one");
    end
endmodule

// File: rtl/bias_truncate.sv
module bias_truncate #(
    parameter int     MU     = 14,
    parameter int     LAMBDA = 12,
    parameter int     ACC_W  = 17,
    parameter longint BIAS   = 0
) (
    input  logic [ACC_W-1:0]  acc_i,
    output logic [LAMBDA-1:0] y_o
);
    logic [ACC_W-1:0] sum;
    logic             sat;

    always_comb begin
        sum = acc_i + ACC_W'(BIAS);
        sat = (sum[ACC_W-1:MU] != '0);
        y_o = sat ? '1 : sum[MU-1 -: LAMBDA];
    end

    always_comb begin
        if (!$isunknown(acc_i))
            assert_bias_nonneg_R4: assert (y_o >= acc_i[MU-1 -: LAMBDA])
                else $error("output fell below the truncated kept sum");
    end
endmodule

// File: rtl/trunc_power.sv
module trunc_power
    import trunc_power_pkg::*;
#(
    parameter int K      = 2,
    parameter int W      = 9,
    parameter int MU     = 14,
    parameter int LAMBDA = 12
) (
    input  logic [W-1:0]      x_i,
    output logic [LAMBDA-1:0] y_o
);
    localparam int          N     = W + 1;
    localparam int          ACC_W = acc_width(MU);
    localparam longint      BIAS  = centre_bias(K, N, MU);
    localparam power_kind_e KIND  = (K == 3) ? PWR_CUBE : PWR_SQUARE;

    logic [N-1:0]     z;
    logic [ACC_W-1:0] acc;

    assign z = {x_i, 1'b1};   // implicit half-ulp below the operand

    generate
        if (KIND == PWR_SQUARE) begin : g_square
            square_array #(.N(N), .MU(MU), .ACC_W(ACC_W)) u_array (
                .z_i  (z),
                .acc_o(acc)
            );
        end else begin : g_cube
            cube_array #(.N(N), .MU(MU), .ACC_W(ACC_W)) u_array (
                .z_i  (z),
                .acc_o(acc)
            );
        end
    endgenerate

    bias_truncate #(.MU(MU), .LAMBDA(LAMBDA), .ACC_W(ACC_W), .BIAS(BIAS)) u_round (
        .acc_i(acc),
        .y_o  (y_o)
    );

    always_comb begin
        if (!$isunknown(x_i)) begin
            assert_msb_follows_R6: assert (x_i[W-1] || !y_o[LAMBDA-1])
                else $error("output MSB set for an operand below one half");
            assert_no_wrap_R2: assert (x_i != '1 || y_o[LAMBDA-1])
                else $error("largest operand wrapped");
        end
    end
endmodule

// File: tb/test_trunc_power.sv
module test_trunc_power;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [8:0] xa; logic [11:0] ya;   // K=2 W=9 MU=14 L=12
    logic [5:0] xc; logic [9:0]  yc;   // K=3 W=6 MU=14 L=10
    logic [3:0] xe; logic [5:0]  ye;   // K=2 W=4 MU=10 L=6 (nothing dropped)
    logic [8:0] xn; logic [13:0] yn;   // K=2 W=9 MU=14 L=14 (no truncation)

    trunc_power i_trunc_power (.x_i(xa), .y_o(ya));
    trunc_power #(.K(3), .W(6), .MU(14), .LAMBDA(10)) i_trunc_power_cube  (.x_i(xc), .y_o(yc));
    trunc_power #(.K(2), .W(4), .MU(10), .LAMBDA(6))  i_trunc_power_exact (.x_i(xe), .y_o(ye));
    trunc_power #(.K(2), .W(9), .MU(14), .LAMBDA(14)) i_trunc_power_nocut (.x_i(xn), .y_o(yn));

    // Dropped mass from ordered position tuples, units 2^-(k*n).
    function automatic longint ref_mass(input int k, input int n, input int mu);
        longint s = 0;
        for (int p = 1; p <= n; p++)
            for (int q = 1; q <= n; q++)
                if (k == 2) begin
                    if (p + q > mu) s += longint'(1) <<< (k * n - p - q);
                end else begin
                    for (int r = 1; r <= n; r++)
                        if (p + q + r > mu) s += longint'(1) <<< (k * n - p - q - r);
                end
        return s;
    endfunction

    function automatic longint ref_power(input longint x, input int k);
        longint z = 2 * x + 1;
        return (k == 2) ? z * z : z * z * z;
    endfunction

    task automatic grade(input string req, input longint x, input longint y,
                         input int k, input int n, input int mu, input int l);
        longint p   = ref_power(x, k);
        int     d   = k * n - l;
        longint err = (y <<< d) - p;
        longint lim = ref_mass(k, n, mu) + (longint'(2) <<< (k * n - mu)) + (longint'(2) <<< d);
        if (err < 0) err = -err;
        n_vec++;
        if (2 * err >= lim) begin
            n_bad++;
            $display("FAIL %s x=%0d: actual y=%0d, expected 2*|y*2^%0d-%0d| < %0d", req, x, y, d, p, lim);
        end
    endtask

    task automatic t_min_operand;
        @(posedge clk); #1 xa = 9'd0; xe = 4'd0;
        @(negedge clk);
        grade("R1", 0, longint'(ya), 2, 10, 14, 12);
        n_vec++;
        if (ye !== 6'd0) begin n_bad++; $display("FAIL R1 x=0: actual %0d expected 0", ye); end
        @(posedge clk); #1 xe = 4'd5;
        @(negedge clk);
        n_vec++;   // z = 11/32, z^2 = 121/1024, floor(121/16) = 7
        if (ye !== 6'd7) begin n_bad++; $display("FAIL R1 x=5: actual %0d expected 7", ye); end
    endtask

    task automatic t_square_sweep;
        for (int x = 0; x < 512; x++) begin
            @(posedge clk); #1 xa = 9'(x);
            @(negedge clk);
            grade("R2", x, longint'(ya), 2, 10, 14, 12);
            if (x < 256) begin
                n_vec++;
                if (ya[11]) begin n_bad++; $display("FAIL R6 x=%0d: actual msb 1 expected 0", x); end
            end
        end
        n_vec++;
        if (!ya[11]) begin n_bad++; $display("FAIL R2 no-wrap: actual y=%0d expected msb set", ya); end
    endtask

    task automatic t_cube_sweep;
        for (int x = 0; x < 64; x++) begin
            @(posedge clk); #1 xc = 6'(x);
            @(negedge clk);
            grade("R5", x, longint'(yc), 3, 7, 14, 10);
        end
    endtask

    task automatic t_exact_sweep;
        for (int x = 0; x < 16; x++) begin
            longint want;
            @(posedge clk); #1 xe = 4'(x);
            @(negedge clk);
            want = ref_power(x, 2) >>> 4;
            n_vec++;
            if (longint'(ye) != want) begin
                n_bad++;
                $display("FAIL R3 x=%0d: actual %0d expected %0d", x, ye, want);
            end
        end
    endtask

    task automatic t_nocut_sweep;
        for (int x = 0; x < 512; x++) begin
            @(posedge clk); #1 xn = 9'(x);
            @(negedge clk);
            grade("R4", x, longint'(yn), 2, 10, 14, 14);
        end
    endtask

    task automatic t_follow;
        @(posedge clk); #1 xa = 9'd500;
        @(negedge clk);
        grade("R7", 500, longint'(ya), 2, 10, 14, 12);
        @(posedge clk); #1 xa = 9'd3;
        @(negedge clk);
        grade("R7", 3, longint'(ya), 2, 10, 14, 12);
        @(posedge clk); #1 xa = 9'd511;
        @(negedge clk);
        grade("R7", 511, longint'(ya), 2, 10, 14, 12);
    endtask

    initial begin
        xa = '0; xc = '0; xe = '0; xn = '0;
        repeat (3) @(posedge clk);
        t_min_operand();
        t_square_sweep();
        t_cube_sweep();
        t_exact_sweep();
        t_nocut_sweep();
        t_follow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R7 watchdog: actual timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule